// File: doc/BRIEF.md
# Twelve-pin GPIO controller with per-pin interrupt triggers

This block is a register-mapped general-purpose I/O controller for up to twelve pins. It sits on a plain 32-bit register bus made of an address, a write strobe with write data, and a read strobe with read data. Each pin has an output value, a drive-enable bit and an input path through a two-flop synchroniser. The synchronised input feeds a per-pin trigger detector. Software picks one of five trigger kinds for each pin: falling edge, rising edge, both edges, low level or high level.

Detected triggers latch into a status vector. Writing ones to a dedicated acknowledge word clears status bits. A per-pin mask is raised and lowered through two separate write-one words. The single interrupt line is the registered OR of every status bit that is both enabled and unmasked. A software reset word holds the whole block at its reset state for as long as its bit 0 stays at 1. A pin-use word drives a vector for an external pin multiplexer.

Top module: `gpioc_top`

## Requirements
- R1: After reset every word reads 0. The word offsets are: 0x00 enable, 0x04 status, 0x08 masked view, 0x0C acknowledge, 0x10 mask raise, 0x14 mask lower, 0x18 output value, 0x1C input level, 0x20 drive enable, 0x24 trigger word A, 0x28 trigger word B, 0x38 pin use, 0x3C soft reset. Offsets 0x2C to 0x34 and the acknowledge word read 0. In every per-pin word, bits at or above the pin count read 0.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. The input-level word returns `pin_in` through a two-flop synchroniser. A read issued at edge k therefore returns the pin value that was present two edges earlier.
- R3: Writing a 1 to a bit at 0x10 masks that pin, and writing a 1 to a bit at 0x14 unmasks it. Zero bits in either write leave the mask unchanged. Reads at either offset return the mask.
- R4: `pin_oe` equals the drive-enable word (1 means drive). `pin_out` equals the output-value word, which reads back what was written.
- R5: Each pin has a 3-bit trigger code: 0 falling, 1 rising, 2 low level, 3 high level, 4 both edges. Pins 0–7 use word A, and pins 8–11 use word B at bits [4k+2:4k], where k is the pin index within the word. Bit 4k+3 of each field reads 0.
- R6: A pin in an edge mode sets its status bit on a matching transition of the synchronised input, and the bit stays set until a 1 is written to its bit at 0x0C. Zero bits in that write have no effect.
- R7: A pin in a level mode sets its status bit on every clock while the level is present. An acknowledge write therefore has no lasting effect until the pin goes inactive.
- R8: A status bit can be set only while the pin's enable bit is 1. Trigger codes 5, 6 and 7 never set status.
- R9: The masked view word reads status AND enable AND NOT mask. `irq_out` is the OR of those bits, registered one clock later.
- R10: When a trigger and an acknowledge for the same pin land in the same cycle, the status bit ends that cycle set.
- R11: While bit 0 of 0x3C is 1, every other register is held at its reset value and writes to those registers are ignored. Writing 0 releases the hold. The soft reset word reads back bit 0.
- R12: The pin-use word is read/write, and its value drives `pin_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (32) | Registered read data |
| pin_in | input | N (12) | Raw pin levels, asynchronous |
| pin_out | output | N (12) | Output value per pin |
| pin_oe | output | N (12) | Drive enable per pin |
| pin_sel | output | N (12) | Pin-use select vector |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The case of interest is a fresh trigger and an acknowledge for the same pin landing in the same cycle. The bench moves a pin in rising-edge mode and counts the two synchroniser flops. It places the acknowledge write strobe exactly on the edge where the detector sees the transition. A following status read must still show the bit set. A second acknowledge one cycle later must then empty it, which proves the first acknowledge was really in that cycle and lost to the trigger.

// File: rtl/gpioc_pkg.sv
package gpioc_pkg;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_VIEW   = 8'h08;
  localparam logic [7:0] OFS_ACK    = 8'h0C;
  localparam logic [7:0] OFS_MRAISE = 8'h10;
  localparam logic [7:0] OFS_MLOWER = 8'h14;
  localparam logic [7:0] OFS_DOUT   = 8'h18;
  localparam logic [7:0] OFS_DIN    = 8'h1C;
  localparam logic [7:0] OFS_DRIVE  = 8'h20;
  localparam logic [7:0] OFS_TRIG_A = 8'h24;
  localparam logic [7:0] OFS_TRIG_B = 8'h28;
  localparam logic [7:0] OFS_PINUSE = 8'h38;
  localparam logic [7:0] OFS_SOFTRST = 8'h3C;

  localparam int TRIG_PITCH = 4;
  localparam int PINS_PER_TRIG_WORD = 8;

endpackage

// File: rtl/gpioc_sync.sv
module gpioc_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);

  logic [W-1:0] meta_q;

  // two capture stages, plus one history stage for edge compare
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
      q_d    <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_d    <= q;
    end
  end

endmodule

// File: rtl/gpioc_trig.sv
module gpioc_trig
  import gpioc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  trig_e mode,
  input  logic  lvl,
  input  logic  lvl_d,
  input  logic  en,
  input  logic  ack,
  output logic  stat
);

  logic hit;

  always_comb begin
    case (mode)
      TRIG_FALL: hit = lvl_d & ~lvl;
      TRIG_RISE: hit = ~lvl_d & lvl;
      TRIG_LOW:  hit = ~lvl;
      TRIG_HIGH: hit = lvl;
      TRIG_BOTH: hit = lvl_d ^ lvl;
      default:   hit = 1'b0;
    endcase
  end

  // a new trigger outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst)           stat <= 1'b0;
    else if (en & hit) stat <= 1'b1;
    else if (ack)      stat <= 1'b0;
  end

endmodule

// File: rtl/gpioc_top.sv
module gpioc_top
  import gpioc_pkg::*;
#(
  parameter int N  = 12,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_sel,
  output logic          irq_out
);

  localparam int LO_N = (N < PINS_PER_TRIG_WORD) ? N : PINS_PER_TRIG_WORD;
  localparam int HI_N = N - LO_N;
  localparam int PAD  = DW - N;

  function automatic logic [DW-1:0] zext(input logic [N-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  logic          srst_q;
  logic          blk_rst;
  logic [N-1:0]  en_q, mask_q, dout_q, dir_q, sel_q;
  trig_e         mode_q [N];
  logic [N-1:0]  s_now, s_prev, stat_v, ack_v, wlo;
  logic [DW-1:0] rd_mux, trig_a_rd, trig_b_rd;
  logic          irq_q;

  assign blk_rst = rst | srst_q;
  assign wlo     = bus_wdata[N-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      srst_q <= 1'b0;
    else if (bus_wr && bus_addr == AW'(OFS_SOFTRST))
      srst_q <= bus_wdata[0];
  end

  gpioc_sync #(.W(N)) u_sync (
    .clk (clk),
    .rst (blk_rst),
    .d   (pin_in),
    .q   (s_now),
    .q_d (s_prev)
  );

  assign ack_v = (bus_wr && bus_addr == AW'(OFS_ACK)) ? wlo : '0;

  for (genvar g = 0; g < N; g++) begin : g_pin
    gpioc_trig u_trig (
      .clk   (clk),
      .rst   (blk_rst),
      .mode  (mode_q[g]),
      .lvl   (s_now[g]),
      .lvl_d (s_prev[g]),
      .en    (en_q[g]),
      .ack   (ack_v[g]),
      .stat  (stat_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (blk_rst) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      sel_q  <= '0;
      for (int p = 0; p < N; p++) mode_q[p] <= TRIG_FALL;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(OFS_ENABLE): en_q   <= wlo;
        AW'(OFS_MRAISE): mask_q <= mask_q | wlo;
        AW'(OFS_MLOWER): mask_q <= mask_q & ~wlo;
        AW'(OFS_DOUT):   dout_q <= wlo;
        AW'(OFS_DRIVE):  dir_q  <= wlo;
        AW'(OFS_PINUSE): sel_q  <= wlo;
        AW'(OFS_TRIG_A):
          for (int p = 0; p < LO_N; p++)
            mode_q[p] <= trig_e'(bus_wdata[TRIG_PITCH*p +: 3]);
        AW'(OFS_TRIG_B):
          for (int p = 0; p < HI_N; p++)
            mode_q[LO_N+p] <= trig_e'(bus_wdata[TRIG_PITCH*p +: 3]);
        default: ;
      endcase
    end
  end

  always_comb begin
    trig_a_rd = '0;
    trig_b_rd = '0;
    for (int p = 0; p < LO_N; p++) trig_a_rd[TRIG_PITCH*p +: 3] = mode_q[p];
    for (int p = 0; p < HI_N; p++) trig_b_rd[TRIG_PITCH*p +: 3] = mode_q[LO_N+p];
    case (bus_addr)
      AW'(OFS_ENABLE):  rd_mux = zext(en_q);
      AW'(OFS_STATUS):  rd_mux = zext(stat_v);
      AW'(OFS_VIEW):    rd_mux = zext(stat_v & en_q & ~mask_q);
      AW'(OFS_MRAISE):  rd_mux = zext(mask_q);
      AW'(OFS_MLOWER):  rd_mux = zext(mask_q);
      AW'(OFS_DOUT):    rd_mux = zext(dout_q);
      AW'(OFS_DIN):     rd_mux = zext(s_now);
      AW'(OFS_DRIVE):   rd_mux = zext(dir_q);
      AW'(OFS_TRIG_A):  rd_mux = trig_a_rd;
      AW'(OFS_TRIG_B):  rd_mux = trig_b_rd;
      AW'(OFS_PINUSE):  rd_mux = zext(sel_q);
      AW'(OFS_SOFTRST): rd_mux = {{(DW-1){1'b0}}, srst_q};
      default:          rd_mux = '0;
    endcase
  end

  // read port survives the soft reset so the hold bit stays visible
  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (blk_rst) irq_q <= 1'b0;
    else         irq_q <= |(stat_v & en_q & ~mask_q);
  end

  assign irq_out = irq_q;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign pin_sel = sel_q;

endmodule

// File: rtl/gpioc_chk.sv
module gpioc_chk
  import gpioc_pkg::*;
#(
  parameter int N  = 12,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          srst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [N-1:0]  wlo,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic [N-1:0]  pin_in,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic          irq_out,
  input logic [N-1:0]  stat,
  input logic [N-1:0]  en,
  input logic [N-1:0]  mask
);

  logic [1:0] settle_q;

  always_ff @(posedge clk) begin
    if (rst || srst)        settle_q <= '0;
    else if (settle_q != 2) settle_q <= settle_q + 2'd1;
  end

  // R2: input-level read shows the pin two edges before the read edge
  a_r2_din_latency: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(OFS_DIN) && settle_q == 2)
      |=> bus_rdata == {{(DW-N){1'b0}}, $past(pin_in, 3)});

  // R3: raising every mask bit silences the line two edges later
  a_r3_mask_all_silences: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(OFS_MRAISE) && (&wlo)) |=> ##1 !irq_out);

  // R4: drive enable follows a drive-word write
  a_r4_oe_follows_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(OFS_DRIVE) && !srst) |=> pin_oe == $past(wlo));

  // R9: the line only rises from an enabled, unmasked status bit
  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(stat & en & ~mask)));

  // R11: a held soft reset keeps the outputs quiet
  a_r11_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (srst && $past(srst)) |-> (pin_oe == '0 && pin_out == '0 && !irq_out));

endmodule

bind gpioc_top gpioc_chk #(.N(N), .AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .srst      (srst_q),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .wlo       (bus_wdata[N-1:0]),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .stat      (stat_v),
  .en        (en_q),
  .mask      (mask_q)
);

// File: tb/gpioc_top_tb_top.sv
`timescale 1ns/1ps
module gpioc_top_tb_top;

  localparam int N = 12;
  localparam logic [7:0] A_EN = 8'h00, A_ST = 8'h04, A_VIEW = 8'h08, A_ACK = 8'h0C;
  localparam logic [7:0] A_MSET = 8'h10, A_MCLR = 8'h14, A_DOUT = 8'h18, A_DIN = 8'h1C;
  localparam logic [7:0] A_DIR = 8'h20, A_TA = 8'h24, A_TB = 8'h28, A_USE = 8'h38, A_SR = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pin_sel;
  logic irq_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpioc_top #(.N(N), .AW(8), .DW(32)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_sel(pin_sel), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    for (int a = 0; a < 64; a += 4) begin
      rd(8'(a), v);
      chk($sformatf("R1 reset read at 0x%02h", a), v, 32'h0);
    end
    chk("R1 reset irq_out", 32'(irq_out), 32'h0);
    chk("R1 reset pin_oe", 32'(pin_oe), 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_MSET, 32'h00F); rd(A_MSET, v); chk("R3 raise", v, 32'h00F);
    wr(A_MSET, 32'h0F0); rd(A_MSET, v); chk("R3 raise keeps zeros", v, 32'h0FF);
    wr(A_MCLR, 32'h003); rd(A_MCLR, v); chk("R3 lower", v, 32'h0FC);
    wr(A_MCLR, 32'hFFF); rd(A_MSET, v); chk("R3 lower all", v, 32'h0);
  endtask

  task automatic t_io();
    logic [31:0] v;
    wr(A_DIR, 32'h0F0); wr(A_DOUT, 32'hFFFF_FFFF);
    chk("R4 pin_oe", 32'(pin_oe), 32'h0F0);
    chk("R4 pin_out", 32'(pin_out), 32'hFFF);
    rd(A_DOUT, v); chk("R4 dout readback upper zero", v, 32'hFFF);
    wr(A_DIR, 32'h0); wr(A_DOUT, 32'h0);
    chk("R4 pin_oe cleared", 32'(pin_oe), 32'h0);
  endtask

  task automatic t_din();
    logic [31:0] v;
    pin_in = 12'h5A3; idle(6);
    rd(A_DIN, v); chk("R2 input level", v, 32'h5A3);
    @(negedge clk);
    pin_in = 12'h3C6; bus_addr = A_DIN; bus_rd = 1'b1;
    @(negedge clk); chk("R2 latency edge 1", bus_rdata, 32'h5A3);
    @(negedge clk); chk("R2 latency edge 2", bus_rdata, 32'h5A3);
    @(negedge clk); chk("R2 latency edge 3", bus_rdata, 32'h3C6);
    bus_rd = 1'b0;
    pin_in = '0; idle(6);
  endtask

  task automatic t_mode_rw();
    logic [31:0] v;
    wr(A_TA, 32'hFFFF_FFFF); rd(A_TA, v); chk("R5 word A fields", v, 32'h7777_7777);
    wr(A_TB, 32'hFFFF_FFFF); rd(A_TB, v); chk("R5 word B fields", v, 32'h0000_7777);
    wr(A_TA, 32'h1234_5678); rd(A_TA, v); chk("R5 word A pattern", v, 32'h1234_5670);
    wr(A_TA, 32'h0); wr(A_TB, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_TA, 32'h1); wr(A_EN, 32'h1);
    pin_in[0] = 1'b1; idle(6);
    rd(A_ST, v); chk("R6 rising sets", v, 32'h1);
    wr(A_ACK, 32'hFFE); rd(A_ST, v); chk("R6 zero ack bits ignored", v, 32'h1);
    pin_in[0] = 1'b0; idle(6);
    wr(A_ACK, 32'h1); idle(4);
    rd(A_ST, v); chk("R6 ack clears edge", v, 32'h0);
    wr(A_TA, 32'h0);
    pin_in[0] = 1'b1; idle(6);
    rd(A_ST, v); chk("R6 rise ignored in falling mode", v, 32'h0);
    pin_in[0] = 1'b0; idle(6);
    rd(A_ST, v); chk("R6 falling sets", v, 32'h1);
    wr(A_ACK, 32'h1);
    wr(A_TB, 32'h4); wr(A_EN, 32'h100);
    pin_in[8] = 1'b1; idle(6);
    rd(A_ST, v); chk("R5 pin8 both-edge rise via word B", v, 32'h100);
    wr(A_ACK, 32'h100);
    pin_in[8] = 1'b0; idle(6);
    rd(A_ST, v); chk("R6 both-edge fall", v, 32'h100);
    wr(A_ACK, 32'h100); wr(A_EN, 32'h0); wr(A_TB, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pin_in[2] = 1'b1;
    wr(A_TA, 32'h0000_0230); idle(6);
    wr(A_EN, 32'h6);
    pin_in[1] = 1'b1; idle(6);
    rd(A_ST, v); chk("R7 high level sets", v, 32'h2);
    wr(A_ACK, 32'h2); rd(A_ST, v); chk("R7 ack while high has no effect", v, 32'h2);
    pin_in[1] = 1'b0; idle(6);
    wr(A_ACK, 32'h2); idle(2);
    rd(A_ST, v); chk("R7 ack after release clears", v, 32'h0);
    pin_in[2] = 1'b0; idle(6);
    rd(A_ST, v); chk("R7 low level sets", v, 32'h4);
    wr(A_ACK, 32'h4); rd(A_ST, v); chk("R7 ack while low has no effect", v, 32'h4);
    pin_in[2] = 1'b1; idle(6);
    wr(A_ACK, 32'h4); wr(A_EN, 32'h0); pin_in[2] = 1'b0;
    wr(A_TA, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(A_TA, 32'h0001_5000); wr(A_EN, 32'h8);
    pin_in[3] = 1'b1; pin_in[4] = 1'b1; idle(6);
    pin_in[3] = 1'b0; pin_in[4] = 1'b0; idle(6);
    rd(A_ST, v); chk("R8 code 5 and disabled pin never set", v, 32'h0);
    wr(A_EN, 32'h0); wr(A_TA, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_TA, 32'h1); wr(A_EN, 32'h1);
    pin_in[0] = 1'b1; idle(6);
    chk("R9 irq raised", 32'(irq_out), 32'h1);
    rd(A_VIEW, v); chk("R9 view shows pin", v, 32'h1);
    wr(A_MSET, 32'hFFF); idle(2);
    chk("R9 masked irq low", 32'(irq_out), 32'h0);
    rd(A_VIEW, v); chk("R9 masked view", v, 32'h0);
    rd(A_ST, v); chk("R9 status kept under mask", v, 32'h1);
    wr(A_MCLR, 32'h1); idle(2);
    chk("R3 unmask restores irq", 32'(irq_out), 32'h1);
    wr(A_EN, 32'h0); idle(2);
    chk("R9 disabled irq low", 32'(irq_out), 32'h0);
    rd(A_ST, v); chk("R9 status held when disabled", v, 32'h1);
    wr(A_ACK, 32'h1); wr(A_MCLR, 32'hFFF);
    pin_in[0] = 1'b0; wr(A_TA, 32'h0); idle(4);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(A_TA, 32'h0010_0000); wr(A_EN, 32'h20);
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_ACK; bus_wdata = 32'h20; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_ST, v); chk("R10 trigger wins over same-cycle ack", v, 32'h20);
    wr(A_ACK, 32'h20);
    rd(A_ST, v); chk("R10 later ack clears", v, 32'h0);
    wr(A_EN, 32'h0); pin_in[5] = 1'b0; wr(A_TA, 32'h0); idle(4);
  endtask

  task automatic t_softrst();
    logic [31:0] v;
    wr(A_DIR, 32'hFFF); wr(A_DOUT, 32'hA5A); wr(A_USE, 32'h3);
    wr(A_MSET, 32'h0F0); wr(A_EN, 32'h00F);
    wr(A_SR, 32'h1); idle(2);
    chk("R11 hold pin_oe", 32'(pin_oe), 32'h0);
    chk("R11 hold pin_out", 32'(pin_out), 32'h0);
    chk("R11 hold pin_sel", 32'(pin_sel), 32'h0);
    wr(A_DIR, 32'hFFF);
    rd(A_SR, v); chk("R11 hold bit reads 1", v, 32'h1);
    rd(A_DIR, v); chk("R11 write ignored in hold", v, 32'h0);
    wr(A_SR, 32'h0);
    rd(A_SR, v); chk("R11 release reads 0", v, 32'h0);
    rd(A_MSET, v); chk("R11 mask back to reset", v, 32'h0);
    rd(A_EN, v); chk("R11 enable back to reset", v, 32'h0);
    wr(A_DIR, 32'h00F);
    chk("R11 writes accepted after release", 32'(pin_oe), 32'h00F);
    wr(A_DIR, 32'h0);
  endtask

  task automatic t_pinsel();
    logic [31:0] v;
    wr(A_USE, 32'hFFFF_FFFF);
    chk("R12 pin_sel drive", 32'(pin_sel), 32'hFFF);
    rd(A_USE, v); chk("R12 readback upper bits zero (R1)", v, 32'hFFF);
    wr(A_USE, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset_state();
    t_mask();
    t_io();
    t_din();
    t_mode_rw();
    t_edge();
    t_level();
    t_gate();
    t_irq();
    t_race();
    t_softrst();
    t_pinsel();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule